// File: doc/BRIEF.md
# Legacy I/O Port Address Translator

This block accepts accesses aimed at a legacy 16-bit I/O port space and turns each one into a single transaction on a local memory-mapped bus. The result is a bus offset, an access width (byte or halfword) and write data placed on the correct byte lane. Read data coming back from the bus is shifted to the requester's byte position, and a response is returned to the requester. A requester can ask for a byte or a 16-bit access, to read or to write.

Peripherals on the local bus are wired in one of three ways, and the bus offset and access width depend on which one applies. Four programmable port windows describe the wiring. Each window holds a lowest port, a highest port and a device class. The class says whether the device has 8 data lines, 16 data lines with all byte traffic on the low lane, or 16 data lines with odd bytes on the high lane. No signal from the device selects the width while an access is in progress, so the width comes only from the class.

Configuration writes arrive on a separate port and are held back until the translator is idle. Only one bus transaction is outstanding at any time.

Top module: `ioport_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_valid` and `rsp_valid` are 0. Every window is empty, so any request receives an error response.
- R2: A byte request to a window of class 2'b00 (8-bit device) issues a byte access (`bus_half`=0) at offset port<<2. Examples: 0x2f8 goes to 0xbe0 and 0x2f9 goes to 0xbe4.
- R3: For class 2'b01 (16-bit device, low lane only), a byte request goes to offset (port with bit 0 cleared)<<1. An even port issues a byte access with the data on bits 7:0. An odd port issues a halfword access: write data goes on bits 15:8 with bits 7:0 at zero, and read data is taken from bits 15:8. Examples: 0x3e0 goes to 0x7c0 as a byte, and 0x3e1 goes to 0x7c0 as a halfword.
- R4: For class 2'b10 (16-bit device, both lanes), a byte request issues a byte access at offset ((port with bit 0 cleared)<<1) + port bit 0. When that offset is odd, the data uses bits 15:8. Example: 0x101 goes to 0x201.
- R5: A 16-bit request to an even port in a class 2'b01 or 2'b10 window issues a halfword access at (port with bit 0 cleared)<<1, with all 16 data bits passed through unchanged.
- R6: A 16-bit request to an odd port, or to a window of class 2'b00, is given an error response with read data 16'hffff, and no bus access is made.
- R7: A port that matches no window, or that first matches a window of class 2'b11, is given an error response with read data 16'hffff, and no bus access is made.
- R8: A port matches a window when base <= port <= limit. When several windows match, the one with the lowest index decides.
- R9: Once a request is accepted, `req_ready` stays 0 until its response has been delivered. The bus fields stay stable while `bus_valid` is 1 and `bus_done` is 0.
- R10: `rsp_valid` rises for one cycle, in the cycle after the one in which `bus_done` is sampled with `bus_valid` high. For an error, it rises in the cycle after the request is accepted.
- R11: A configuration write takes effect only when the translator is idle. A transaction already in progress keeps its translation, and `req_ready` is 0 in the cycle after `cfg_we`.
- R12: The response to a successful byte read has bits 15:8 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_port | input | 16 | I/O port number |
| req_wide | input | 1 | 1 = 16-bit request, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 16 | Read data (byte in bits 7:0) |
| bus_valid | output | 1 | Bus transaction pending |
| bus_offset | output | 18 | Bus byte offset |
| bus_half | output | 1 | 1 = halfword access, 0 = byte |
| bus_write | output | 1 | Bus write |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_done | input | 1 | Bus completes the transaction |
| bus_rdata | input | 16 | Bus read data, valid with bus_done |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Window index |
| cfg_base | input | 16 | Lowest port of the window |
| cfg_limit | input | 16 | Highest port of the window |
| cfg_class | input | 2 | Device class code |

## Verification
A wrong window priority or a stale class register shows up in the very first bus cycle after acceptance, as a wrong offset or a wrong `bus_half`. A lane-steering fault shows up in `bus_wdata` in that same cycle. A wrong read extraction shows up one cycle after `bus_done`. A corrupted state register shows as a missing or doubled `rsp_valid`, or as `req_ready` returning while the bus is still busy, and the assertions flag this within a cycle. A configuration that takes effect too early changes the fields of a transaction that is already in flight.

// File: rtl/ioport_xlate.sv
module ioport_xlate #(
  parameter int PORT_W = 16,
  parameter int WIN    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PORT_W-1:0]   req_port,
  input  logic                req_wide,
  input  logic                req_write,
  input  logic [15:0]         req_wdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [15:0]         rsp_rdata,
  output logic                bus_valid,
  output logic [PORT_W+1:0]   bus_offset,
  output logic                bus_half,
  output logic                bus_write,
  output logic [15:0]         bus_wdata,
  input  logic                bus_done,
  input  logic [15:0]         bus_rdata,
  input  logic                cfg_we,
  input  logic [$clog2(WIN)-1:0] cfg_idx,
  input  logic [PORT_W-1:0]   cfg_base,
  input  logic [PORT_W-1:0]   cfg_limit,
  input  logic [1:0]          cfg_class
);
  localparam int IDX_W = $clog2(WIN);
  localparam int OFS_W = PORT_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RESP} st_t;

  st_t                st;
  logic [PORT_W-1:0]  w_base [WIN];
  logic [PORT_W-1:0]  w_lim  [WIN];
  logic [1:0]         w_cls  [WIN];

  logic               p_v;
  logic [IDX_W-1:0]   p_idx;
  logic [PORT_W-1:0]  p_base, p_lim;
  logic [1:0]         p_cls;

  logic [OFS_W-1:0]   b_ofs;
  logic               b_half, b_write, b_hi, b_wide;
  logic [15:0]        b_wdata;
  logic               r_err;
  logic [15:0]        r_data;

  logic               hit;
  logic [1:0]         cls;
  logic               odd, bad, d_half, d_hi;
  logic [OFS_W-1:0]   ofs8, ofs16, d_ofs;
  logic [15:0]        d_wdata;
  logic               accept;

  always_comb begin
    hit = 1'b0;
    cls = 2'b00;
    for (int i = WIN - 1; i >= 0; i--) begin
      if (req_port >= w_base[i] && req_port <= w_lim[i]) begin
        hit = 1'b1;
        cls = w_cls[i];
      end
    end
  end

  assign odd   = req_port[0];
  assign ofs8  = {req_port, 2'b00};
  assign ofs16 = {1'b0, req_port[PORT_W-1:1], 2'b00};
  assign bad   = !hit || cls == 2'b11 || (req_wide && (odd || cls == 2'b00));

  always_comb begin
    d_ofs  = ofs16;
    d_half = 1'b0;
    d_hi   = 1'b0;
    case (cls)
      2'b00: d_ofs = ofs8;
      2'b01: begin
        d_half = req_wide | odd;
        d_hi   = !req_wide & odd;
      end
      2'b10: begin
        d_ofs  = ofs16 | {{(OFS_W-1){1'b0}}, !req_wide & odd};
        d_half = req_wide;
        d_hi   = !req_wide & odd;
      end
      default: ;
    endcase
  end

  assign d_wdata = req_wide ? req_wdata :
                   d_hi     ? {req_wdata[7:0], 8'h00} : {8'h00, req_wdata[7:0]};

  assign req_ready = st == ST_IDLE && !p_v;
  assign accept    = req_valid && req_ready;
  assign bus_valid = st == ST_BUS;
  assign rsp_valid = st == ST_RESP;
  assign bus_offset = b_ofs;
  assign bus_half   = b_half;
  assign bus_write  = b_write;
  assign bus_wdata  = b_wdata;
  assign rsp_err    = r_err;
  assign rsp_rdata  = r_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_v    <= 1'b0;
      p_idx  <= '0;
      p_base <= '0;
      p_lim  <= '0;
      p_cls  <= 2'b00;
      for (int i = 0; i < WIN; i++) begin
        w_base[i] <= '1;
        w_lim[i]  <= '0;
        w_cls[i]  <= 2'b00;
      end
    end else begin
      if (st == ST_IDLE && p_v) begin
        w_base[p_idx] <= p_base;
        w_lim[p_idx]  <= p_lim;
        w_cls[p_idx]  <= p_cls;
        p_v           <= 1'b0;
      end
      if (cfg_we) begin
        p_v    <= 1'b1;
        p_idx  <= cfg_idx;
        p_base <= cfg_base;
        p_lim  <= cfg_limit;
        p_cls  <= cfg_class;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      b_ofs   <= '0;
      b_half  <= 1'b0;
      b_write <= 1'b0;
      b_hi    <= 1'b0;
      b_wide  <= 1'b0;
      b_wdata <= '0;
      r_err   <= 1'b0;
      r_data  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          if (bad) begin
            r_err  <= 1'b1;
            r_data <= 16'hffff;
            st     <= ST_RESP;
          end else begin
            b_ofs   <= d_ofs;
            b_half  <= d_half;
            b_write <= req_write;
            b_hi    <= d_hi;
            b_wide  <= req_wide;
            b_wdata <= d_wdata;
            st      <= ST_BUS;
          end
        end
        ST_BUS: if (bus_done) begin
          r_err  <= 1'b0;
          r_data <= b_wide ? bus_rdata :
                    b_hi   ? {8'h00, bus_rdata[15:8]} : {8'h00, bus_rdata[7:0]};
          st     <= ST_RESP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module ioport_xlate_chk #(
  parameter int PORT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_wide,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [15:0]       rsp_rdata,
  input logic              bus_valid,
  input logic [PORT_W+1:0] bus_offset,
  input logic              bus_half,
  input logic              bus_write,
  input logic [15:0]       bus_wdata,
  input logic              bus_done,
  input logic              cfg_we
);
  logic wide_q;
  always_ff @(posedge clk) begin
    if (!rst_n) wide_q <= 1'b0;
    else if (req_valid && req_ready) wide_q <= req_wide;
  end

  assert_bus_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_done |=> bus_valid && $stable(bus_offset) && $stable(bus_half)
      && $stable(bus_write) && $stable(bus_wdata));

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid || rsp_valid) |-> !req_ready);

  assert_rsp_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_done |=> rsp_valid && !rsp_err && !bus_valid);

  assert_rsp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_err_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == 16'hffff && !$past(bus_valid));

  assert_half_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_half |-> !bus_offset[0]);

  assert_byte_upper_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && !wide_q |-> rsp_rdata[15:8] == 8'h00);

  assert_cfg_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !req_ready);
endmodule

bind ioport_xlate ioport_xlate_chk #(.PORT_W(PORT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_wide(req_wide), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .bus_valid(bus_valid), .bus_offset(bus_offset),
  .bus_half(bus_half), .bus_write(bus_write), .bus_wdata(bus_wdata),
  .bus_done(bus_done), .cfg_we(cfg_we)
);

// File: tb/test_ioport_xlate.sv
module test_ioport_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_wide = 1'b0, req_write = 1'b0;
  logic [15:0] req_port = '0, req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic bus_valid, bus_half, bus_write;
  logic [17:0] bus_offset;
  logic [15:0] bus_wdata;
  logic bus_done = 1'b0;
  logic [15:0] bus_rdata = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0, cfg_class = '0;
  logic [15:0] cfg_base = '0, cfg_limit = '0;

  int vectors = 0, miscompares = 0;
  logic [15:0] m_base [4];
  logic [15:0] m_lim  [4];
  logic [1:0]  m_cls  [4];

  always #4 clk = ~clk;

  ioport_xlate i_ioport_xlate (.*);

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic [15:0] b, input logic [15:0] l, input logic [1:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_base = b; cfg_limit = l; cfg_class = c;
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[idx] = b; m_lim[idx] = l; m_cls[idx] = c;
    @(negedge clk);
  endtask

  task automatic predict(input logic [15:0] p, input logic w, input logic [15:0] wd,
                         input logic [15:0] rd, output logic err, output logic [17:0] ofs,
                         output logic half, output logic [15:0] ewd, output logic [15:0] erd);
    logic hit, hi;
    logic [1:0] c;
    hit = 0; c = 0;
    for (int i = 3; i >= 0; i--)
      if (p >= m_base[i] && p <= m_lim[i]) begin hit = 1; c = m_cls[i]; end
    err = !hit || c == 2'b11 || (w && (p[0] || c == 2'b00));
    hi = 0; half = 0;
    ofs = {1'b0, p[15:1], 1'b0} << 1;
    if (c == 2'b00) ofs = {p, 2'b00};
    else if (c == 2'b01) begin half = w | p[0]; hi = !w & p[0]; end
    else begin half = w; hi = !w & p[0]; ofs = ofs + {17'd0, !w & p[0]}; end
    ewd = w ? wd : hi ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
    erd = err ? 16'hffff : w ? rd : hi ? {8'h00, rd[15:8]} : {8'h00, rd[7:0]};
  endtask

  task automatic xfer(input logic [15:0] p, input logic w, input logic wr,
                      input logic [15:0] wd, input logic [15:0] rd, input int dly,
                      input string tag, input bit cfg_mid = 0);
    logic err, half;
    logic [17:0] ofs;
    logic [15:0] ewd, erd;
    predict(p, w, wd, rd, err, ofs, half, ewd, erd);
    @(negedge clk);
    req_valid = 1; req_port = p; req_wide = w; req_write = wr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (err) begin
      chk(!bus_valid, {tag, " R6/R7 no bus on error"}, 32'(bus_valid), 0);
      chk(rsp_valid && rsp_err && rsp_rdata == 16'hffff, {tag, " R6/R7 error response"},
          {rsp_valid, rsp_err, rsp_rdata}, {2'b11, 16'hffff});
    end else begin
      chk(bus_valid && bus_offset == ofs, {tag, " offset"}, 32'(bus_offset), 32'(ofs));
      chk(bus_half == half, {tag, " width"}, 32'(bus_half), 32'(half));
      chk(bus_write == wr, {tag, " direction"}, 32'(bus_write), 32'(wr));
      if (wr) chk(bus_wdata == ewd, {tag, " lane data"}, 32'(bus_wdata), 32'(ewd));
      chk(!req_ready, {tag, " R9 ready low while busy"}, 32'(req_ready), 0);
      for (int k = 0; k < dly; k++) begin
        if (cfg_mid && k == 0) begin
          cfg_we = 1; cfg_idx = 0; cfg_base = 16'h3e0; cfg_limit = 16'h3e1; cfg_class = 2'b10;
          @(negedge clk);
          cfg_we = 0;
          m_base[0] = 16'h3e0; m_lim[0] = 16'h3e1; m_cls[0] = 2'b10;
        end else @(negedge clk);
        chk(bus_valid && bus_offset == ofs && bus_half == half, {tag, " R9/R11 held"},
            32'(bus_offset), 32'(ofs));
      end
      bus_done = 1; bus_rdata = rd;
      @(negedge clk);
      bus_done = 0;
      chk(rsp_valid && !rsp_err, {tag, " R10 response timing"}, {rsp_valid, rsp_err}, 2'b10);
      chk(rsp_rdata == erd, {tag, " read data"}, 32'(rsp_rdata), 32'(erd));
    end
    @(negedge clk);
    chk(!rsp_valid, {tag, " R10 single pulse"}, 32'(rsp_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd20110706));
    for (int i = 0; i < 4; i++) begin m_base[i] = 16'hffff; m_lim[i] = 0; m_cls[i] = 0; end
    repeat (4) @(negedge clk);
    chk(req_ready && !bus_valid && !rsp_valid, "R1 reset outputs",
        {req_ready, bus_valid, rsp_valid}, 3'b100);
    rst_n = 1;
    xfer(16'h3f8, 0, 0, 0, 16'h1234, 0, "R1 empty windows");

    cfg(0, 16'h3e0, 16'h3e1, 2'b01);
    cfg(1, 16'h2f8, 16'h2ff, 2'b00);
    cfg(2, 16'h100, 16'h10f, 2'b10);
    cfg(3, 16'h000, 16'h3ff, 2'b00);

    xfer(16'h2f8, 0, 0, 0, 16'hab5a, 1, "R2 8-bit 0x2f8");
    xfer(16'h2f9, 0, 1, 16'h0077, 0, 0, "R2 8-bit 0x2f9");
    xfer(16'h3e0, 0, 1, 16'hff31, 0, 0, "R3 low-lane even");
    xfer(16'h3e1, 0, 1, 16'h00c4, 0, 2, "R3 low-lane odd write");
    xfer(16'h3e1, 0, 0, 0, 16'h9e07, 0, "R3/R12 low-lane odd read");
    xfer(16'h101, 0, 0, 0, 16'h5aa5, 1, "R4/R12 both-lane odd");
    xfer(16'h100, 0, 1, 16'h0042, 0, 0, "R4 both-lane even");
    xfer(16'h104, 1, 1, 16'hbeef, 16'h0, 0, "R5 wide write");
    xfer(16'h3e0, 1, 0, 0, 16'hcafe, 3, "R5 wide read");
    xfer(16'h103, 1, 0, 0, 16'h1111, 0, "R6 wide odd port");
    xfer(16'h2fa, 1, 0, 0, 16'h1111, 0, "R6 wide on 8-bit");
    xfer(16'h105, 0, 0, 0, 16'h3c00, 0, "R8 lower index wins");
    xfer(16'h500, 0, 0, 0, 16'h1111, 0, "R7 no match");
    xfer(16'h3e1, 0, 0, 0, 16'h8811, 3, "R11 cfg during bus", 1);
    xfer(16'h3e1, 0, 0, 0, 16'h8811, 0, "R11 new class applied");
    cfg(3, 16'h000, 16'h3ff, 2'b11);
    xfer(16'h200, 0, 0, 0, 16'h1111, 0, "R7 reserved class");
    cfg(3, 16'h000, 16'h3ff, 2'b01);

    for (int n = 0; n < 400; n++) begin
      logic [15:0] p;
      p = 16'h0f0 + 16'($urandom % 16'h340);
      xfer(p, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
           int'($urandom % 4), "R2/R3/R4/R5/R6/R7/R8/R12 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule